// File: doc/BRIEF.md
# Serial-Read Parallel Input Port with Change Interrupt

This block lets an SPI master read a bank of digital input pins. While the select line is high it keeps following the pins. On the falling edge of select it takes a snapshot of the pins. That snapshot is then clocked out on the serial data output, most significant bit first, in SPI mode 0. The data-out enable is active only while the block is selected, so several devices can share one data-out wire.

The pin bank is built from 8-bit stages, and the number of stages is a parameter. The serial data input enters the least significant stage. Each stage passes its top bit on to the next stage. A wider chain is therefore read in one select period: the host gives one select assertion, then one SCK pulse per bit. Bits that arrive on the serial input come out after the last pin bit.

A separate active-low interrupt line reports that a synchronised pin differs from the snapshot taken at the last select. It is released at the next select falling edge.

All port inputs pass through a synchroniser in the system clock domain before they are used.

Top module: `spi_pin_port`

## Requirements
- R1: While `ss_n` is high, the shift register follows the synchronised pins. After `ss_n` falls, the first bit on `miso_d` is bit W-1 of the pin value at select, where W = 8·STAGES.
- R2: Pin changes made after `ss_n` has fallen do not alter the data read during that select period.
- R3: Data leaves MSB first. `miso_d` changes after SCK falling edges and is stable when SCK rises, so a master samples it on the rising edge.
- R4: A bit on `mosi` is captured on an SCK rising edge and enters bit 0. After W further SCK pulses it appears on `miso_d`, so bit W+k of a read equals the k-th `mosi` bit sent.
- R5: `miso_oe` is 1 while selected and 0 while deselected.
- R6: `irq_n` goes low when the synchronised pins differ from the snapshot taken at the last select. It returns high at the next `ss_n` falling edge.
- R7: If `ss_n` rises partway through a read, the shift is abandoned. The next select reads the then-current pins, starting from bit W-1.
- R8: SCK pulses while `ss_n` is high cause no shifting. A read that follows them starts at bit W-1 of the pins.
- R9: After reset, `irq_n` is 1 and `miso_oe` is 0. The snapshot reset value is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8·STAGES | Parallel input pins |
| ss_n | input | 1 | Select, active low |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial chain input |
| miso_d | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso_d` (tri-state control) |
| irq_n | output | 1 | Pin-change interrupt, active low |

## Verification
The bench builds the port with two stages (16 pins) and a two-flop synchroniser. With two stages, bits that enter on `mosi` must cross the boundary between stages. A 32-pulse read then shows the complete chained path from `mosi` to `miso_d`. The narrow width keeps reads short, so the bench can cover many situations in a small number of cycles: an aborted read, SCK pulses while deselected, pin changes in the middle of a read, and the release of the interrupt.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;
   localparam int LANES_PER_STAGE = 8;

   typedef struct packed {
      logic sel;       // synchronised select, active high
      logic sel_fall;  // first cycle of a select period
      logic sck_rise;  // qualified by select
      logic sck_fall;  // qualified by select
      logic mosi;      // synchronised serial input
   } spi_evt_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int WIDTH = 1,
   parameter int DEPTH = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pin_sync: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("pin_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[DEPTH-1];
endmodule

// File: rtl/spi_edge_front.sv
module spi_edge_front
   import spi_pin_pkg::*;
#(
   parameter int SYNC_DEPTH = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ss_n,
   input  logic     sck,
   input  logic     mosi,
   output spi_evt_t evt
);
   logic [2:0] raw_w, sync_w;
   logic       ss_q, sck_q;
   logic       ss_s, sck_s, mosi_s;

   assign raw_w = {ss_n, sck, mosi};

   pin_sync #(
      .WIDTH   (3),
      .DEPTH   (SYNC_DEPTH),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_w),
      .q     (sync_w)
   );

   assign {ss_s, sck_s, mosi_s} = sync_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ss_q  <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         ss_q  <= ss_s;
         sck_q <= sck_s;
      end
   end

   always_comb begin
      evt.sel      = ~ss_s;
      evt.sel_fall = ss_q & ~ss_s;
      evt.sck_rise = ~ss_s & ~sck_q & sck_s;
      evt.sck_fall = ~ss_s & sck_q & ~sck_s;
      evt.mosi     = mosi_s;
   end
endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
   parameter int LANES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic [LANES-1:0] par,
   input  logic             ser_in,
   output logic             ser_out,
   output logic [LANES-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (load)   q <= par;
      else if (shift)  q <= {q[LANES-2:0], ser_in};
   end

   assign ser_out = q[LANES-1];
endmodule

// File: rtl/irq_tracker.sv
module irq_tracker #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pins,
   input  logic             capture,
   output logic             irq_n
);
   logic [WIDTH-1:0] snap;
   logic             pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap    <= '0;
         pending <= 1'b0;
      end else if (capture) begin
         snap    <= pins;
         pending <= 1'b0;
      end else if (pins != snap) begin
         pending <= 1'b1;
      end
   end

   assign irq_n = ~pending;
endmodule

// File: rtl/spi_pin_port.sv
module spi_pin_port
   import spi_pin_pkg::*;
#(
   parameter int STAGES     = 2,
   parameter int SYNC_DEPTH = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [STAGES*LANES_PER_STAGE-1:0] pins_i,
   input  logic                              ss_n,
   input  logic                              sck,
   input  logic                              mosi,
   output logic                              miso_d,
   output logic                              miso_oe,
   output logic                              irq_n
);
   localparam int W = STAGES * LANES_PER_STAGE;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("spi_pin_port: STAGES must be at least 1");
      end
   endgenerate

   spi_evt_t     evt;
   logic [W-1:0] pins_s;
   logic [W-1:0] sr_all;
   logic [STAGES:0] link;
   logic         mosi_cap;
   logic         sel_w, sel_fall_w, sck_fall_w;
   logic         load_w, shift_w;

   spi_edge_front #(.SYNC_DEPTH(SYNC_DEPTH)) u_front (
      .clk   (clk),
      .rst_n (rst_n),
      .ss_n  (ss_n),
      .sck   (sck),
      .mosi  (mosi),
      .evt   (evt)
   );

   pin_sync #(.WIDTH(W), .DEPTH(SYNC_DEPTH), .RST_VAL('0)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_i),
      .q     (pins_s)
   );

   assign sel_w      = evt.sel;
   assign sel_fall_w = evt.sel_fall;
   assign sck_fall_w = evt.sck_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            mosi_cap <= 1'b0;
      else if (evt.sck_rise) mosi_cap <= evt.mosi;
   end

   assign load_w  = ~sel_w | sel_fall_w;
   assign shift_w = sel_w & ~sel_fall_w & sck_fall_w;

   assign link[0] = mosi_cap;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         shift_stage #(.LANES(LANES_PER_STAGE)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_w),
            .shift   (shift_w),
            .par     (pins_s[g*LANES_PER_STAGE +: LANES_PER_STAGE]),
            .ser_in  (link[g]),
            .ser_out (link[g+1]),
            .q       (sr_all[g*LANES_PER_STAGE +: LANES_PER_STAGE])
         );
      end
   endgenerate

   irq_tracker #(.WIDTH(W)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins    (pins_s),
      .capture (sel_fall_w),
      .irq_n   (irq_n)
   );

   assign miso_d  = link[STAGES];
   assign miso_oe = sel_w;
endmodule

// File: rtl/spi_pin_port_chk.sv
module spi_pin_port_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         sel,
   input logic         sel_fall,
   input logic         sck_fall,
   input logic [W-1:0] pins_s,
   input logic [W-1:0] sr,
   input logic         irq_n
);
   AST_TRACK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sel) |-> sr == $past(pins_s));  // R1

   AST_SNAPSHOT_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sel_fall) |-> sr == $past(pins_s));  // R2

   AST_HOLD_WITHOUT_SCK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel) && !$past(sel_fall) && !$past(sck_fall)) |-> $stable(sr));  // R2

   AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel) && !$past(sel_fall) && $past(sck_fall))
         |-> sr[W-1:1] == $past(sr[W-2:0]));  // R3

   AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fall |=> irq_n);  // R6
endmodule

bind spi_pin_port spi_pin_port_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel      (sel_w),
   .sel_fall (sel_fall_w),
   .sck_fall (sck_fall_w),
   .pins_s   (pins_s),
   .sr       (sr_all),
   .irq_n    (irq_n)
);

// File: tb/tb_spi_pin_port.sv
`timescale 1ns/1ps
module tb_spi_pin_port;
   localparam int STAGES = 2;
   localparam int W      = STAGES * 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [W-1:0] pins_i;
   logic         ss_n, sck, mosi;
   logic         miso_d, miso_oe, irq_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   typedef struct {
      logic  b;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   always #2.5 clk = ~clk;

   spi_pin_port #(.STAGES(STAGES), .SYNC_DEPTH(2)) dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_i  (pins_i),
      .ss_n    (ss_n),
      .sck     (sck),
      .mosi    (mosi),
      .miso_d  (miso_d),
      .miso_oe (miso_oe),
      .irq_n   (irq_n)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: compares each bit at the master's sampling edge
   always @(posedge sck) begin
      if (!ss_n) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected bit", {31'd0, miso_d}, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(miso_d === e.b, e.tag, {31'd0, miso_d}, {31'd0, e.b});
         end
      end
   end

   task automatic half();
      repeat (8) @(negedge clk);
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic xfer(input logic [2*W-1:0] exp_w, input int nbits,
                       input logic [2*W-1:0] mosi_w, input string tag,
                       input bit chg, input logic [W-1:0] chg_val);
      ss_n = 1'b0;
      half();
      check(miso_oe === 1'b1, "R5 oe selected", {31'd0, miso_oe}, 32'd1);
      if (chg) pins_i = chg_val;
      for (int i = 0; i < nbits; i++) begin
         exp_t e;
         e.b   = exp_w[2*W-1-i];
         e.tag = tag;
         exp_q.push_back(e);
         mosi = mosi_w[2*W-1-i];
         half();
         sck = 1'b1;
         half();
         sck = 1'b0;
      end
      half();
      ss_n = 1'b1;
      mosi = 1'b0;
      settle();
      check(miso_oe === 1'b0, "R5 oe deselected", {31'd0, miso_oe}, 32'd0);
      check(exp_q.size() == 0, "R3 all bits seen", exp_q.size(), 32'd0);
   endtask

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         check(1'b0, "watchdog", 32'd0, 32'd1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n  = 1'b0;
      pins_i = '0;
      ss_n   = 1'b1;
      sck    = 1'b0;
      mosi   = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      settle();

      // R9: reset state
      check(irq_n === 1'b1, "R9 irq_n after reset", {31'd0, irq_n}, 32'd1);
      check(miso_oe === 1'b0, "R9 oe after reset", {31'd0, miso_oe}, 32'd0);

      // R6: change against zero snapshot raises irq
      pins_i = 16'hA5C3;
      settle();
      check(irq_n === 1'b0, "R6 irq on change", {31'd0, irq_n}, 32'd0);

      // R1: plain read of current pins
      xfer({16'hA5C3, 16'h0}, W, '0, "R1", 1'b0, '0);
      check(irq_n === 1'b1, "R6 irq released", {31'd0, irq_n}, 32'd1);

      // R2: pins change after select, snapshot must hold
      pins_i = 16'h3C5A;
      settle();
      xfer({16'h3C5A, 16'h0}, W, '0, "R2", 1'b1, 16'hFFFF);
      check(irq_n === 1'b0, "R6 irq after mid-read change", {31'd0, irq_n}, 32'd0);

      // R4: chained read, mosi data returns after W bits
      xfer({16'hFFFF, 16'hB2E1}, 2*W, {16'hB2E1, 16'h0}, "R4", 1'b0, '0);
      check(irq_n === 1'b1, "R6 irq released again", {31'd0, irq_n}, 32'd1);

      // R3: MSB/LSB boundary patterns
      pins_i = 16'h8001;
      settle();
      xfer({16'h8001, 16'h0}, W, '0, "R3", 1'b0, '0);
      pins_i = 16'h0000;
      settle();
      xfer({16'h0000, 16'h0}, W, {16'hFFFF, 16'h0}, "R3", 1'b0, '0);

      // R7: abort mid-byte, then read fresh pins from MSB
      pins_i = 16'h1234;
      settle();
      xfer({16'h1234, 16'h0}, 5, '0, "R7 partial", 1'b0, '0);
      pins_i = 16'h8E71;
      settle();
      xfer({16'h8E71, 16'h0}, W, '0, "R7", 1'b0, '0);

      // R8: SCK pulses while deselected are ignored
      pins_i = 16'h4321;
      settle();
      for (int k = 0; k < 6; k++) begin
         half();
         sck = 1'b1;
         half();
         sck = 1'b0;
      end
      settle();
      check(miso_oe === 1'b0, "R8 oe while idle sck", {31'd0, miso_oe}, 32'd0);
      xfer({16'h4321, 16'h0}, W, '0, "R8", 1'b0, '0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule